// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel with a byte-wide write interface. A control write picks one of three behaviours: a one-shot that fires on terminal count, a periodic rate generator, or a software-started strobe. The same write selects whether a count load takes one byte or two. Count writes hold the starting value. A newly written value reaches the counting element only after the counter clock shows a rising edge and then a falling edge following the final byte. The counter decrements once on each falling edge after that.

The counter clock `ctr_clk` is a level that is already synchronous to `clk`. The block detects its edges by comparing each sample with the one before. The gate is treated as permanently enabled. Writing a new control word stops the channel and sets the output to a level fixed by the mode. In two-byte format, the low byte freezes counting and the high byte restarts it with the new value. The counting element is brought out on `count_o` so that the count can be observed.

Top module: `tmr_chan`

## Requirements
- R1: After reset, `out_o` is 0, `count_o` is 0 and the channel is idle. Count writes made before the first control write are ignored.
- R2: A control write takes `wdata[1:0]` as the mode (00 terminal-count, 01 rate generator, 10 or 11 strobe) and `wdata[4]` as the format (1 = two bytes, 0 = one byte). It stops counting at once and freezes `count_o`. From the following cycle, `out_o` is 0 in terminal-count mode and 1 in the other two modes.
- R3: After the final byte of a count is written, the value reaches `count_o` on the first counter-clock falling edge that follows a rising edge seen after the write. A falling edge with no later rising edge before it does not transfer the value.
- R4: In two-byte format the low byte is written first, then the high byte. Writing the low byte halts decrementing and leaves `count_o` unchanged until the new value is transferred.
- R5: In one-byte format the count is `{8'h00, byte}`. A count that is already running keeps decrementing until the new value is transferred.
- R6: While running, `count_o` drops by one on each counter-clock falling edge and wraps from 0000h to FFFFh.
- R7: In terminal-count mode, `out_o` goes to 1 when a decrement reaches 0. It stays at 1 through the wrap until the next control write or load.
- R8: In rate-generator mode, `out_o` is 0 exactly while the count is 1. On the next falling edge the loaded value reloads and `out_o` returns to 1, which gives a period of N counter clocks.
- R9: In strobe mode, `out_o` goes low for one counter clock when a decrement reaches 0, and does so only once per load. The count does not reload. A loaded 0 means 65536 counter clocks and gives no pulse at load time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control-word write strobe |
| cnt_we | input | 1 | Count-byte write strobe |
| wdata | input | 8 | Write data byte |
| ctr_clk | input | 1 | Counter clock level, synchronous to `clk` |
| out_o | output | 1 | Timer output pin |
| count_o | output | 16 | Current counting-element value |

## Verification
A stale mode register or a bad load flag shows at the ports within one counter-clock falling edge. Either `count_o` fails to take the written value, or it keeps moving after a halting write. A wrong output decode in the periodic or strobe modes shows on the edge where the count reaches 1 or 0: `out_o` goes low too early, too late, or a second time. The slowest symptom is a missed terminal-count latch, which needs a run through the wrap to expose. The bench drives exactly that run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int BYTE_W = 8;
    localparam int CNT_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        MD_TERM = 2'b00,
        MD_RATE = 2'b01,
        MD_STRB = 2'b10
    } md_t;

    function automatic md_t md_decode(input logic [1:0] code);
        case (code)
            2'b00:   return MD_TERM;
            2'b01:   return MD_RATE;
            default: return MD_STRB;
        endcase
    endfunction
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/tmr_loader.sv
module tmr_loader
    import tmr_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          cnt_we,
    input  logic [BW-1:0] wdata,
    input  logic          rise,
    input  logic          fall,
    output md_t           mode_o,
    output logic          halt_o,
    output logic          xfer_o,
    output logic [CW-1:0] value_o
);
    typedef struct packed {
        md_t           mode;
        logic          two;
        logic          cfg;
        logic          hi_wait;
        logic [BW-1:0] lo;
        logic          pend;
        logic          seen;
        logic [CW-1:0] value;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d   = ld_q;
        halt_o = 1'b0;
        xfer_o = ld_q.pend & ld_q.seen & fall;
        if (ld_q.pend && rise) ld_d.seen = 1'b1;
        if (xfer_o) begin
            ld_d.pend = 1'b0;
            ld_d.seen = 1'b0;
        end
        if (ctl_we) begin
            ld_d.mode    = md_decode(wdata[1:0]);
            ld_d.two     = wdata[4];
            ld_d.cfg     = 1'b1;
            ld_d.hi_wait = 1'b0;
            ld_d.pend    = 1'b0;
            ld_d.seen    = 1'b0;
        end else if (cnt_we && ld_q.cfg) begin
            ld_d.seen = 1'b0;
            if (ld_q.two && !ld_q.hi_wait) begin
                ld_d.lo      = wdata;
                ld_d.hi_wait = 1'b1;
                ld_d.pend    = 1'b0;
                halt_o       = 1'b1;
            end else if (ld_q.two) begin
                ld_d.value   = {wdata, ld_q.lo};
                ld_d.hi_wait = 1'b0;
                ld_d.pend    = 1'b1;
            end else begin
                ld_d.value = {{BW{1'b0}}, wdata};
                ld_d.pend  = 1'b1;
            end
        end
        mode_o  = ld_q.mode;
        value_o = ld_q.value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q      <= '0;
            ld_q.mode <= MD_TERM;
        end else begin
            ld_q <= ld_d;
        end
    end

    // R1: nothing is pending before the first control word
    p_no_pend_unconfigured_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_q.cfg |-> !ld_q.pend);
    // R4: the low byte of a two-byte load withdraws any pending value
    p_lo_byte_cancels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !ld_q.pend);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          cnt_we,
    input  logic [BW-1:0] wdata,
    input  logic          ctr_clk,
    output logic          out_o,
    output logic [CW-1:0] count_o
);
    logic          rise, fall, halt, xfer;
    md_t           mode;
    logic [CW-1:0] xval;

    tmr_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ctr_clk), .rise(rise), .fall(fall)
    );

    tmr_loader #(.BW(BW)) u_ld (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cnt_we(cnt_we),
        .wdata(wdata), .rise(rise), .fall(fall), .mode_o(mode),
        .halt_o(halt), .xfer_o(xfer), .value_o(xval)
    );

    typedef struct packed {
        logic          run;
        logic          out;
        logic          done;
        logic [CW-1:0] count;
        logic [CW-1:0] reload;
    } ch_t;

    ch_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (ctl_we) begin
            ch_d.run  = 1'b0;
            ch_d.done = 1'b0;
            ch_d.out  = (md_decode(wdata[1:0]) != MD_TERM);
        end else if (halt) begin
            ch_d.run = 1'b0;
        end else if (xfer) begin
            ch_d.run    = 1'b1;
            ch_d.done   = 1'b0;
            ch_d.count  = xval;
            ch_d.reload = xval;
            ch_d.out    = (mode != MD_TERM);
        end else if (ch_q.run && fall) begin
            case (mode)
                MD_TERM: begin
                    ch_d.count = ch_q.count - 1'b1;
                    if (ch_q.count == CW'(1)) ch_d.out = 1'b1;
                end
                MD_RATE: begin
                    if (ch_q.count == CW'(1)) begin
                        ch_d.count = ch_q.reload;
                        ch_d.out   = 1'b1;
                    end else begin
                        ch_d.count = ch_q.count - 1'b1;
                        ch_d.out   = (ch_q.count != CW'(2));
                    end
                end
                default: begin
                    ch_d.count = ch_q.count - 1'b1;
                    if (ch_q.count == CW'(1) && !ch_q.done) begin
                        ch_d.out  = 1'b0;
                        ch_d.done = 1'b1;
                    end else begin
                        ch_d.out = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign out_o   = ch_q.out;
    assign count_o = ch_q.count;

    p_mode_freezes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> $stable(ch_q.count));
    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !ctl_we && !halt) |=> (ch_q.count == $past(xval)));
    p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_q.run && !xfer) |=> $stable(ch_q.count));
    p_term_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_TERM && ch_q.out && !ctl_we && !xfer) |=> ch_q.out);
    p_rate_low_at_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.run && mode == MD_RATE && !ch_q.out) |-> (ch_q.count == CW'(1)));
    p_strobe_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STRB && ch_q.done && ch_q.out && !ctl_we && !xfer) |=> ch_q.out);
endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0, ctl_we = 1'b0, cnt_we = 1'b0, ctr_clk = 1'b0;
    logic [7:0]  wdata = '0;
    logic        out_o;
    logic [15:0] count_o;
    int          n_tot = 0, n_bad = 0;

    tmr_chan dut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cnt_we(cnt_we),
                  .wdata(wdata), .ctr_clk(ctr_clk), .out_o(out_o), .count_o(count_o));

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [1:0]  md;
        logic        two;
        logic [15:0] cnt;
        logic [7:0]  ticks;
        logic        eout;
        logic [15:0] ecnt;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'd0, 1'b1, 16'd5, 8'd1, 1'b0, 16'd5},      // R7 load
        '{2'd0, 1'b1, 16'd5, 8'd5, 1'b0, 16'd1},      // R7 before zero
        '{2'd0, 1'b1, 16'd5, 8'd6, 1'b1, 16'd0},      // R7 terminal
        '{2'd0, 1'b1, 16'd5, 8'd8, 1'b1, 16'hFFFE},   // R6 wrap, R7 held
        '{2'd1, 1'b1, 16'd4, 8'd3, 1'b1, 16'd2},      // R8
        '{2'd1, 1'b1, 16'd4, 8'd4, 1'b0, 16'd1},      // R8 low at one
        '{2'd1, 1'b1, 16'd4, 8'd5, 1'b1, 16'd4},      // R8 reload
        '{2'd1, 1'b1, 16'd4, 8'd8, 1'b0, 16'd1},      // R8 second period
        '{2'd2, 1'b1, 16'd3, 8'd3, 1'b1, 16'd1},      // R9
        '{2'd2, 1'b1, 16'd3, 8'd4, 1'b0, 16'd0},      // R9 strobe
        '{2'd3, 1'b1, 16'd3, 8'd5, 1'b1, 16'hFFFF},   // R9 no reload
        '{2'd0, 1'b0, 16'd7, 8'd2, 1'b0, 16'd6}       // R5 one-byte
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit ctl, input logic [7:0] b);
        @(negedge clk);
        wdata = b; ctl_we = ctl; cnt_we = ~ctl;
        @(negedge clk);
        ctl_we = 1'b0; cnt_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); ctr_clk = 1'b1;
        @(negedge clk); ctr_clk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tot++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_o == 1'b0, "R1 reset out", out_o, 0);
        chk(count_o == 16'h0, "R1 reset count", count_o, 0);
        wr(1'b0, 8'h09);
        tick(); tick();
        chk(count_o == 16'h0, "R1 count before mode", count_o, 0);

        foreach (VEC[i]) begin
            vec_t v = VEC[i];
            string t = (v.md == 2'd0) ? "R7" : (v.md == 2'd1) ? "R8" : "R9";
            wr(1'b1, {3'b0, v.two, 2'b0, v.md});
            if (v.two) begin
                wr(1'b0, v.cnt[7:0]);
                wr(1'b0, v.cnt[15:8]);
            end else begin
                wr(1'b0, v.cnt[7:0]);
            end
            for (int k = 0; k < int'(v.ticks); k++) tick();
            chk(out_o == v.eout, t, out_o, v.eout);
            chk(count_o == v.ecnt, "R6 count", count_o, v.ecnt);
        end

        // R2: mode write stops counting and sets the level
        wr(1'b1, 8'h10); wr(1'b0, 8'h10); wr(1'b0, 8'h00);
        tick(); tick();
        chk(count_o == 16'h000F, "R3 two-byte load", count_o, 16'h000F);
        wr(1'b1, 8'h11);
        chk(out_o == 1'b1, "R2 rate level", out_o, 1);
        tick(); tick();
        chk(count_o == 16'h000F, "R2 halted", count_o, 16'h000F);
        wr(1'b1, 8'h10);
        chk(out_o == 1'b0, "R2 term level", out_o, 0);

        // R4: first byte halts, second restarts
        wr(1'b1, 8'h11); wr(1'b0, 8'h08); wr(1'b0, 8'h00);
        tick(); tick();
        chk(count_o == 16'h0007, "R4 running", count_o, 7);
        wr(1'b0, 8'h20);
        tick(); tick();
        chk(count_o == 16'h0007, "R4 low byte halts", count_o, 7);
        wr(1'b0, 8'h01);
        tick();
        chk(count_o == 16'h0120, "R4 new count", count_o, 16'h0120);
        tick();
        chk(count_o == 16'h011F, "R4 restarted", count_o, 16'h011F);

        // R3 and R5: write while the counter clock is high
        wr(1'b1, 8'h00); wr(1'b0, 8'h30);
        tick(); tick();
        chk(count_o == 16'h002F, "R5 one-byte run", count_o, 16'h2F);
        @(negedge clk); ctr_clk = 1'b1;
        wr(1'b0, 8'h05);
        ctr_clk = 1'b0;
        @(negedge clk);
        chk(count_o == 16'h002E, "R3 no rise no transfer", count_o, 16'h2E);
        tick();
        chk(count_o == 16'h0005, "R3 transfer after rise", count_o, 5);
        chk(out_o == 1'b0, "R7 low after load", out_o, 0);

        // R9: zero load means full range, no pulse at load
        wr(1'b1, 8'h02); wr(1'b0, 8'h00);
        tick();
        chk(out_o == 1'b1 && count_o == 16'h0, "R9 zero load", count_o, 0);
        tick();
        chk(out_o == 1'b1 && count_o == 16'hFFFF, "R9 zero wraps", count_o, 16'hFFFF);

        $display("%0d/%0d checks passed", n_tot - n_bad, n_tot);
        $finish;
    end
endmodule